// File: doc/BRIEF.md
# Trace-Driven Processor Request Sequencer

This block stands in for one processor in a multiprocessor memory model. It holds a short list of memory requests and plays them one at a time into the processor's private cache. Each entry carries a request kind, a word address and a data value. The data value is carried for reads as well as writes. The block presents one entry and waits for the cache to answer. It then moves to the next entry, with no idle cycle between the answer and the next request.

The list has no length count. The run ends at the first entry whose kind is neither a read nor a write. It also ends if the index runs past the last entry of the list. When the run ends, the block emits a one-cycle done pulse, which feeds a system-wide completion count, and raises a finished flag that stays high until reset. The list is loaded through a simple write port before the run begins. A start pulse then launches the run.

Top module: `trace_seq_top`

## Requirements
- R1: After reset, req_valid, done_pulse and finished are all 0. They stay 0 until start is sampled high.
- R2: The kind field is an 8-bit ASCII code. 0x52 ('R') and 0x72 ('r') are reads and drive req_write=0. 0x57 ('W') and 0x77 ('w') are writes and drive req_write=1. Every other value of the 256 codes is an end marker.
- R3: In the cycle after start is sampled high, req_valid is 1 and req_addr, req_data and req_write show entry 0. req_data carries the entry's data for reads too.
- R4: While req_valid is 1 and resp_valid has not been sampled high, req_valid and the request fields hold steady.
- R5: When resp_valid is sampled high at an edge while req_valid is 1, the next entry's request is presented in the cycle right after that edge.
- R6: When the current entry is an end marker, req_valid is 0 in that cycle. done_pulse is 1 for exactly the one cycle that follows. finished is 1 from that cycle until reset, and no further request is issued.
- R7: If all DEPTH entries (16 by default) are reads or writes, the run ends after the response to the last entry, exactly as if an end marker followed it.
- R8: resp_valid has no effect while req_valid is 0 (before start and after finishing).
- R9: start has no effect while a run is active or after finished. Loads through the write port take effect only before start; a load during a run leaves the list unchanged.
- R10: Reset clears every list entry to kind 0x00. A run started on a list that was never loaded therefore ends at once with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the run from entry 0 |
| load_en | input | 1 | Writes one list entry |
| load_idx | input | clog2(DEPTH) | Entry index for the write |
| load_kind | input | 8 | ASCII request kind to store |
| load_addr | input | 16 | Word address to store |
| load_data | input | 32 | Data value to store |
| resp_valid | input | 1 | Cache response for the current request |
| req_valid | output | 1 | A request is presented to the cache |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_addr | output | 16 | Request word address |
| req_data | output | 32 | Request data value |
| done_pulse | output | 1 | One-cycle pulse when the run ends |
| finished | output | 1 | Sticky run-ended flag |

## Verification
The hold and advance checks assume the cache answers each request with a single-cycle resp_valid. They also assume the cache never answers a request that has not been presented. The bench's cache model raises resp_valid for exactly one cycle, and only while a request is visible. The only exception is deliberate stray pulses, sent while idle or finished, that test that a response is ignored. The bench exercises loads and starts during a run only through the ports. It relies on the block to reject them, so the field-stability check rests on that rejection.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

    localparam int KIND_W = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam logic [KIND_W-1:0] KIND_RD_UP = 8'h52;
    localparam logic [KIND_W-1:0] KIND_RD_LO = 8'h72;
    localparam logic [KIND_W-1:0] KIND_WR_UP = 8'h57;
    localparam logic [KIND_W-1:0] KIND_WR_LO = 8'h77;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } trace_entry_t;

    typedef enum logic [1:0] {
        OP_END   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } trace_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    function automatic trace_op_e classify_kind(input logic [KIND_W-1:0] k);
        trace_op_e op;
        case (k)
            KIND_RD_UP, KIND_RD_LO: op = OP_READ;
            KIND_WR_UP, KIND_WR_LO: op = OP_WRITE;
            default:                op = OP_END;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/trace_list_mem.sv
module trace_list_mem
    import trace_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  trace_entry_t      wr_entry,
    input  logic [IDX_W-1:0]  rd_idx,
    output trace_entry_t      rd_entry
);

    trace_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_entry;
        end
    end

    always_comb begin
        rd_entry = slots[rd_idx];
    end

endmodule

// File: rtl/trace_kind_decode.sv
module trace_kind_decode
    import trace_seq_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              in_range,
    output trace_op_e         op,
    output logic              is_write
);

    always_comb begin
        if (in_range) begin
            op = classify_kind(kind);
        end else begin
            op = OP_END;
        end
        is_write = (op == OP_WRITE);
    end

endmodule

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
    import trace_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            resp_valid,
    input  trace_op_e       cur_op,
    output logic [IDX_W:0]  idx,
    output logic            req_valid,
    output logic            load_ok,
    output logic            done_pulse,
    output logic            finished
);

    localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(DEPTH);

    seq_state_e state;

    always_comb begin
        req_valid = (state == ST_RUN) && (cur_op != OP_END);
        load_ok   = (state == ST_IDLE);
        finished  = (state == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            idx        <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx   <= '0;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cur_op == OP_END) begin
                        state      <= ST_FIN;
                        done_pulse <= 1'b1;
                    end else if (resp_valid) begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_FIN: begin
                    state <= ST_FIN;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !resp_valid |=> req_valid && $stable(idx)); // R4

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst)
        req_valid && resp_valid |=> idx == $past(idx) + 1'b1); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse); // R6

    AST_FIN_STICKY: assert property (@(posedge clk) disable iff (rst)
        finished |=> finished && !req_valid); // R6

    AST_FIN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        finished |-> !load_ok); // R9

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX); // R7

endmodule

// File: rtl/trace_seq_top.sv
module trace_seq_top
    import trace_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [KIND_W-1:0] load_kind,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              resp_valid,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              done_pulse,
    output logic              finished
);

    localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(DEPTH);

    trace_entry_t     wr_entry;
    trace_entry_t     cur_entry;
    logic [IDX_W:0]   idx;
    logic             load_ok;
    logic             in_range;
    trace_op_e        cur_op;

    always_comb begin
        wr_entry.kind = load_kind;
        wr_entry.addr = load_addr;
        wr_entry.data = load_data;
        in_range      = (idx < LAST_IDX);
        req_addr      = cur_entry.addr;
        req_data      = cur_entry.data;
    end

    trace_list_mem #(.DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (load_en && load_ok),
        .wr_idx   (load_idx),
        .wr_entry (wr_entry),
        .rd_idx   (idx[IDX_W-1:0]),
        .rd_entry (cur_entry)
    );

    trace_kind_decode u_dec (
        .kind     (cur_entry.kind),
        .in_range (in_range),
        .op       (cur_op),
        .is_write (req_write)
    );

    trace_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .resp_valid (resp_valid),
        .cur_op     (cur_op),
        .idx        (idx),
        .req_valid  (req_valid),
        .load_ok    (load_ok),
        .done_pulse (done_pulse),
        .finished   (finished)
    );

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !resp_valid |=> $stable(req_addr) && $stable(req_data)
                                     && $stable(req_write)); // R4

    AST_NO_REQ_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        load_ok |-> !req_valid && !done_pulse); // R1

endmodule

// File: tb/trace_seq_top_tb.sv
module trace_seq_top_tb;

    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [7:0]  load_kind = '0;
    logic [15:0] load_addr = '0;
    logic [31:0] load_data = '0;
    logic        resp_valid = 1'b0;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [31:0] req_data;
    logic        done_pulse;
    logic        finished;

    int n_chk  = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #5 clk = ~clk;

    trace_seq_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .load_en(load_en),
        .load_idx(load_idx), .load_kind(load_kind), .load_addr(load_addr),
        .load_data(load_data), .resp_valid(resp_valid), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
        .done_pulse(done_pulse), .finished(finished)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit kind_is_rd(input logic [7:0] k);
        return (k == 8'h52) || (k == 8'h72);
    endfunction

    function automatic bit kind_is_wr(input logic [7:0] k);
        return (k == 8'h57) || (k == 8'h77);
    endfunction

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; load_en = 1'b0; resp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input int i, input logic [7:0] k, input logic [15:0] a,
                        input logic [31:0] d);
        load_en = 1'b1; load_idx = IW'(i); load_kind = k; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic respond();
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
    endtask

    task automatic expect_end(input string tag);
        chk({tag, " req_valid low at marker"}, 64'(req_valid), 64'd0);
        chk({tag, " no early done"}, 64'(done_pulse), 64'd0);
        @(negedge clk);
        chk({tag, " done pulse"}, 64'(done_pulse), 64'd1);
        chk({tag, " finished"}, 64'(finished), 64'd1);
        @(negedge clk);
        chk({tag, " done single cycle"}, 64'(done_pulse), 64'd0);
        chk({tag, " finished sticky"}, 64'(finished), 64'd1);
    endtask

    initial begin
        logic [7:0] tk [7];
        @(negedge clk);
        do_reset();

        // R1: reset state and idle quiet
        for (int c = 0; c < 3; c++) begin
            chk("R1 req_valid", 64'(req_valid), 64'd0);
            chk("R1 done_pulse", 64'(done_pulse), 64'd0);
            chk("R1 finished", 64'(finished), 64'd0);
            @(negedge clk);
        end

        // R10: empty list ends at once
        do_start();
        expect_end("R10");

        // R2 sweep of all 256 kind codes, with R3 first request each time
        for (int k = 0; k < 256; k++) begin
            do_reset();
            load(0, 8'h52, 16'h0100, 32'hA5A5_0000);
            load(1, 8'(k), 16'h0200 + 16'(k), 32'h1000 + 32'(k) * 3);
            load(2, 8'h57, 16'h0300, 32'h0);
            do_start();
            chk("R3 first req_valid", 64'(req_valid), 64'd1);
            chk("R3 first addr", 64'(req_addr), 64'h0100);
            chk("R3 read carries data", 64'(req_data), 64'hA5A5_0000);
            chk("R3 read flag", 64'(req_write), 64'd0);
            respond();
            if (kind_is_rd(8'(k)) || kind_is_wr(8'(k))) begin
                chk("R2 op req_valid", 64'(req_valid), 64'd1);
                chk("R2 write flag", 64'(req_write), 64'(kind_is_wr(8'(k))));
                chk("R2 addr", 64'(req_addr), 64'h0200 + 64'(k));
                chk("R2 data", 64'(req_data), 64'h1000 + 64'(k) * 3);
            end else begin
                expect_end("R2 end code");
            end
        end

        // R4/R5/R6/R8: mixed trace with latencies 0..3
        tk[0] = 8'h52; tk[1] = 8'h77; tk[2] = 8'h57; tk[3] = 8'h72;
        tk[4] = 8'h52; tk[5] = 8'h57; tk[6] = 8'h5A;
        do_reset();
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R8 stray resp idle", 64'(req_valid), 64'd0);
        for (int i = 0; i < 7; i++) begin
            load(i, tk[i], 16'h0010 * 16'(i) + 16'h7, 32'hC0DE_0000 + 32'(i));
        end
        do_start();
        for (int i = 0; i < 6; i++) begin
            chk("R5 req_valid", 64'(req_valid), 64'd1);
            chk("R5 addr", 64'(req_addr), 64'h10 * 64'(i) + 64'h7);
            chk("R5 data", 64'(req_data), 64'hC0DE_0000 + 64'(i));
            chk("R5 write flag", 64'(req_write), 64'(kind_is_wr(tk[i])));
            for (int w = 0; w < i % 4; w++) begin
                @(negedge clk);
                chk("R4 held valid", 64'(req_valid), 64'd1);
                chk("R4 held addr", 64'(req_addr), 64'h10 * 64'(i) + 64'h7);
                chk("R4 held data", 64'(req_data), 64'hC0DE_0000 + 64'(i));
            end
            respond();
        end
        expect_end("R6");
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R8 stray resp finished", 64'(req_valid), 64'd0);
        do_start();
        for (int c = 0; c < 3; c++) begin
            chk("R9 restart ignored valid", 64'(req_valid), 64'd0);
            chk("R9 restart ignored done", 64'(done_pulse), 64'd0);
            chk("R9 still finished", 64'(finished), 64'd1);
            @(negedge clk);
        end

        // R9: start and load during a run are ignored
        do_reset();
        load(0, 8'h52, 16'h0001, 32'h11);
        load(1, 8'h57, 16'h0002, 32'h22);
        do_start();
        start = 1'b1; load_en = 1'b1; load_idx = 4'd1;
        load_kind = 8'h52; load_addr = 16'hBEEF; load_data = 32'hDEAD;
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        chk("R9 still on entry 0", 64'(req_addr), 64'h0001);
        respond();
        chk("R9 entry 1 addr kept", 64'(req_addr), 64'h0002);
        chk("R9 entry 1 kind kept", 64'(req_write), 64'd1);
        chk("R9 entry 1 data kept", 64'(req_data), 64'h22);
        respond();
        expect_end("R9 run end");

        // R7: full list ends implicitly
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            load(i, 8'h77, 16'h0400 + 16'(i), 32'(i));
        end
        do_start();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R7 entry addr", 64'(req_addr), 64'h0400 + 64'(i));
            chk("R7 entry valid", 64'(req_valid), 64'd1);
            respond();
        end
        expect_end("R7");

        all_done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule